// File: doc/BRIEF.md
# Software Trigger Command Register

This block is a 32-bit command register through which software fires trigger events into a timer/counter that runs on its own counter clock. Five command bits exist: two capture triggers, a reload, a stop and a start. Writing a one to a command bit marks that trigger as pending. The block carries the request across into the counter clock domain, where it produces a single-cycle trigger pulse. The bit returns to zero only after that pulse has been issued. Software can therefore poll the register to learn when its command has taken effect.

The register sits on a simple bus-clock write/read port: a write strobe with a data word, and a combinational read word. A counter-enable level, owned by the bus clock domain, gates the whole block. When the enable falls, every pending bit is dropped at once without waiting for the counter clock. The counter domain also stops emitting pulses once it sees the enable low.

Each command bit has its own toggle handshake. A toggle goes out through a synchronizer chain, and its echo comes back through a second chain. The bits are fully independent of one another, so any mix of them can be pending at the same time.

Top module: `swtrig_cmd_reg`

## Requirements
- R1: After reset, `rd_data` reads 0 and no bit of `cnt_trig` is high.
- R2: With `cnt_enable` high, a write with a one in a command position sets that bit, and the bit reads back as 1 on the next bus cycle. The command positions are: capture-A at bit 0, reload at bit 2, stop at bit 3, start at bit 4, capture-B at bit 5.
- R3: A zero written to a command position leaves that bit unchanged. Bit 1 and bits 31..6 always read 0, and writes to them have no effect.
- R4: Each accepted request produces exactly one `cnt_trig` pulse, one counter cycle wide, on the lane for that command. The lane indices are: 0 capture-A, 1 reload, 2 stop, 3 start, 4 capture-B.
- R5: A pending bit stays at 1 until its trigger pulse has been issued in the counter domain. It then returns to 0 without any further write.
- R6: Writing one to a bit that is already pending does not queue a second trigger: that request yields a single pulse.
- R7: Several command bits may be pending at once. Each completes independently with its own single pulse.
- R8: While `cnt_enable` is low, `rd_data` reads 0 in the same cycle, all pending bits are cleared, and writes set nothing.
- R9: A request flushed by a disable yields at most one pulse. After re-enable, a new request on the same bit yields exactly one pulse and then clears.
- R10: When a software set and the hardware clear of the same bit fall in the same bus cycle, the set wins. The bit stays 1, and a further trigger pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bus_clk | input | 1 | Bus clock |
| bus_rst_n | input | 1 | Active-low reset, bus domain |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data, one-to-set per command bit |
| rd_data | output | 32 | Register readback (pending command bits) |
| cnt_enable | input | 1 | Counter enable level, bus domain; low flushes all commands |
| cnt_clk | input | 1 | Counter clock |
| cnt_rst_n | input | 1 | Active-low reset, counter domain |
| cnt_trig | output | 5 | Single-cycle trigger pulses, counter domain, one per command |

## Verification
Two events can land on the same bit in the same bus cycle: a new software write of one, and the hardware clear triggered by the returning acknowledge. To provoke this without looking inside the design, the bench holds a write of one to a bit on every bus cycle for hundreds of cycles, so every returning acknowledge is certain to meet a write. The collision is judged correct if the readback never shows 0 during that stretch and more than one pulse comes out. The bench also measures the opposite boundary: a disable that arrives while a toggle is still in flight must empty the register at once, and the handshake must still recover for the next request.

// File: rtl/swtrig_pkg.sv
package swtrig_pkg;

  // Number of command lanes and width of the bus register
  localparam int TRIG_N = 5;
  localparam int REG_W  = 32;

  // Lane indices (also the index into cnt_trig)
  localparam int LANE_CAP_A  = 0;
  localparam int LANE_RELOAD = 1;
  localparam int LANE_STOP   = 2;
  localparam int LANE_START  = 3;
  localparam int LANE_CAP_B  = 4;

  typedef logic [TRIG_N-1:0] lane_vec_t;
  typedef logic [REG_W-1:0]  reg_word_t;

  // Register bit position of each lane; neighbours decode these positions.
  function automatic int unsigned bit_pos(input int unsigned lane);
    case (lane)
      LANE_CAP_A:  bit_pos = 0;
      LANE_RELOAD: bit_pos = 2;
      LANE_STOP:   bit_pos = 3;
      LANE_START:  bit_pos = 4;
      default:     bit_pos = 5;
    endcase
  endfunction

  // Scatter a lane vector into register word positions.
  function automatic reg_word_t place(input lane_vec_t v);
    reg_word_t w;
    w = '0;
    for (int i = 0; i < TRIG_N; i++) begin
      w[bit_pos(i)] = v[i];
    end
    return w;
  endfunction

  // Gather the lane bits out of a register word.
  function automatic lane_vec_t pick(input reg_word_t w);
    lane_vec_t v;
    for (int i = 0; i < TRIG_N; i++) begin
      v[i] = w[bit_pos(i)];
    end
    return v;
  endfunction

  // Positions that hold a command bit.
  function automatic reg_word_t used_mask();
    return place('1);
  endfunction

endpackage

// File: rtl/swtrig_sync.sv
// Multi-flop level synchronizer for a vector of independent bits.
module swtrig_sync #(
  parameter int STAGES = 2,
  parameter int W      = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) stg[k] <= '0;
    end else begin
      stg[0] <= d;
      for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/swtrig_bus_lane.sv
// Bus-domain state for one command bit: pending flag, in-flight flag, request toggle.
module swtrig_bus_lane (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,     // counter enable, bus domain
  input  logic sw_fire,    // write strobe with a one in this bit
  input  logic ack_sync,   // echoed toggle, synchronized into bus domain
  output logic pend,       // visible command bit
  output logic req_tgl,    // request toggle toward counter domain
  output logic hw_clear,   // acknowledge of the issued request arrived
  output logic issue       // a new toggle is launched this cycle
);

  logic sent_q;
  logic busy;
  logic pend_n, sent_n, tgl_n;
  logic pend_mid, sent_mid;

  // A toggle is in flight while the echo differs from the request.
  assign busy     = req_tgl ^ ack_sync;
  assign hw_clear = sent_q & ~busy;

  always_comb begin
    // Step 1: hardware clear of the acknowledged request.
    pend_mid = hw_clear ? 1'b0 : pend;
    sent_mid = hw_clear ? 1'b0 : sent_q;
    // Step 2: software set; a write landing with the clear is a fresh request.
    pend_n   = pend_mid | (sw_fire & enable);
    // Step 3: launch a toggle once the handshake is idle.
    issue    = enable & pend_n & ~sent_mid & ~busy;
    sent_n   = sent_mid | issue;
    tgl_n    = req_tgl ^ issue;
    // Disable drops everything; an in-flight toggle still returns on its own.
    if (!enable) begin
      pend_n = 1'b0;
      sent_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend    <= 1'b0;
      sent_q  <= 1'b0;
      req_tgl <= 1'b0;
    end else begin
      pend    <= pend_n;
      sent_q  <= sent_n;
      req_tgl <= tgl_n;
    end
  end

endmodule

// File: rtl/swtrig_cnt_lane.sv
// Counter-domain side of one command bit: edge detect, pulse, echo.
module swtrig_cnt_lane (
  input  logic clk,
  input  logic rst_n,
  input  logic en_sync,    // counter enable seen in this domain
  input  logic req_sync,   // synchronized request toggle
  output logic trig,       // single-cycle trigger pulse
  output logic ack_tgl     // echo of the toggle after it was acted on
);

  logic req_seen;
  logic arrived;

  assign arrived = req_sync ^ req_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_seen <= 1'b0;
      trig     <= 1'b0;
    end else begin
      req_seen <= req_sync;
      trig     <= arrived & en_sync;
    end
  end

  // The echo follows the level that has just been acted on.
  assign ack_tgl = req_seen;

endmodule

// File: rtl/swtrig_cmd_reg.sv
module swtrig_cmd_reg #(
  parameter int SYNC_STAGES = 2
) (
  input  logic                        bus_clk,
  input  logic                        bus_rst_n,
  input  logic                        wr_en,
  input  logic [swtrig_pkg::REG_W-1:0] wr_data,
  output logic [swtrig_pkg::REG_W-1:0] rd_data,
  input  logic                        cnt_enable,
  input  logic                        cnt_clk,
  input  logic                        cnt_rst_n,
  output logic [swtrig_pkg::TRIG_N-1:0] cnt_trig
);

  import swtrig_pkg::*;

  localparam int N = TRIG_N;

  // Named internal events, brought out for the checker
  lane_vec_t sw_fire;
  lane_vec_t pend_q;
  lane_vec_t hw_clear;
  lane_vec_t issue;
  lane_vec_t req_tgl;
  lane_vec_t req_cnt;
  lane_vec_t ack_tgl;
  lane_vec_t ack_bus;
  logic      en_cnt;

  assign sw_fire = wr_en ? pick(wr_data) : '0;

  // Bus -> counter crossings
  swtrig_sync #(.STAGES(SYNC_STAGES), .W(N)) u_req_sync (
    .clk(cnt_clk), .rst_n(cnt_rst_n), .d(req_tgl), .q(req_cnt)
  );
  swtrig_sync #(.STAGES(SYNC_STAGES), .W(1)) u_en_sync (
    .clk(cnt_clk), .rst_n(cnt_rst_n), .d(cnt_enable), .q(en_cnt)
  );
  // Counter -> bus crossing
  swtrig_sync #(.STAGES(SYNC_STAGES), .W(N)) u_ack_sync (
    .clk(bus_clk), .rst_n(bus_rst_n), .d(ack_tgl), .q(ack_bus)
  );

  for (genvar g = 0; g < N; g++) begin : g_lane
    swtrig_bus_lane u_bus (
      .clk      (bus_clk),
      .rst_n    (bus_rst_n),
      .enable   (cnt_enable),
      .sw_fire  (sw_fire[g]),
      .ack_sync (ack_bus[g]),
      .pend     (pend_q[g]),
      .req_tgl  (req_tgl[g]),
      .hw_clear (hw_clear[g]),
      .issue    (issue[g])
    );
    swtrig_cnt_lane u_cnt (
      .clk      (cnt_clk),
      .rst_n    (cnt_rst_n),
      .en_sync  (en_cnt),
      .req_sync (req_cnt[g]),
      .trig     (cnt_trig[g]),
      .ack_tgl  (ack_tgl[g])
    );
  end

  // Readback masks with the live enable so a disable shows at once.
  assign rd_data = cnt_enable ? place(pend_q) : '0;

endmodule

// File: rtl/swtrig_cmd_reg_chk.sv
module swtrig_cmd_reg_chk (
  input logic                          bus_clk,
  input logic                          bus_rst_n,
  input logic                          cnt_clk,
  input logic                          cnt_rst_n,
  input logic                          cnt_enable,
  input logic                          wr_en,
  input logic [swtrig_pkg::REG_W-1:0]  wr_data,
  input logic [swtrig_pkg::REG_W-1:0]  rd_data,
  input logic [swtrig_pkg::TRIG_N-1:0] cnt_trig,
  input logic [swtrig_pkg::TRIG_N-1:0] pend_q,
  input logic [swtrig_pkg::TRIG_N-1:0] hw_clear
);

  import swtrig_pkg::*;

  // R3
  unused_zero_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    (rd_data & ~used_mask()) == '0);

  // R8
  disable_reads_zero_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
    !cnt_enable |-> rd_data == '0);

  for (genvar g = 0; g < TRIG_N; g++) begin : g_chk
    localparam int unsigned P = bit_pos(g);

    // R2
    set_takes_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      (cnt_enable && wr_en && wr_data[P] && !pend_q[g]) |=> pend_q[g]);

    // R3
    hold_pending_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      (cnt_enable && pend_q[g] && !hw_clear[g]) |=> pend_q[g]);

    // R5
    clear_cause_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      $fell(pend_q[g]) |-> $past(hw_clear[g] || !cnt_enable));

    // R10
    set_beats_clear_chk: assert property (@(posedge bus_clk) disable iff (!bus_rst_n)
      (cnt_enable && hw_clear[g] && wr_en && wr_data[P]) |=> pend_q[g]);

    // R4
    single_pulse_chk: assert property (@(posedge cnt_clk) disable iff (!cnt_rst_n)
      cnt_trig[g] |=> !cnt_trig[g]);
  end

endmodule

bind swtrig_cmd_reg swtrig_cmd_reg_chk u_chk (
  .bus_clk    (bus_clk),
  .bus_rst_n  (bus_rst_n),
  .cnt_clk    (cnt_clk),
  .cnt_rst_n  (cnt_rst_n),
  .cnt_enable (cnt_enable),
  .wr_en      (wr_en),
  .wr_data    (wr_data),
  .rd_data    (rd_data),
  .cnt_trig   (cnt_trig),
  .pend_q     (pend_q),
  .hw_clear   (hw_clear)
);

// File: tb/swtrig_cmd_reg_test.sv
module swtrig_cmd_reg_test;

  localparam int NT = 5;
  localparam int POS [NT] = '{0, 2, 3, 4, 5};

  logic        bus_clk = 1'b0;
  logic        cnt_clk = 1'b0;
  logic        bus_rst_n = 1'b0;
  logic        cnt_rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        cnt_enable = 1'b1;
  logic [NT-1:0] cnt_trig;

  realtime cnt_half = 3.7ns;
  int checks = 0;
  int fails  = 0;
  int pulses [NT];
  int wide_pulses = 0;
  logic [NT-1:0] prev_trig = '0;

  always #2.5ns bus_clk = ~bus_clk;
  always #(cnt_half) cnt_clk = ~cnt_clk;

  swtrig_cmd_reg uut (
    .bus_clk(bus_clk), .bus_rst_n(bus_rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .cnt_enable(cnt_enable), .cnt_clk(cnt_clk),
    .cnt_rst_n(cnt_rst_n), .cnt_trig(cnt_trig)
  );

  initial for (int i = 0; i < NT; i++) pulses[i] = 0;

  // Pulse counter, sampled away from the counter edge
  always @(negedge cnt_clk) begin
    for (int i = 0; i < NT; i++) begin
      if (cnt_trig[i]) begin
        pulses[i]++;
        if (prev_trig[i]) wide_pulses++;
      end
    end
    prev_trig <= cnt_trig;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [31:0] d);
    @(negedge bus_clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge bus_clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge bus_clk);
  endtask

  // Poll until the bit reads 0; returns cycles taken or -1
  task automatic wait_clear(input int pos, output int cyc);
    cyc = -1;
    for (int c = 0; c < 400; c++) begin
      if (!rd_data[pos]) begin cyc = c; break; end
      @(negedge bus_clk);
    end
  endtask

  task automatic t_reset;
    idle(2);
    chk(rd_data == 0, "R1", "rd_data after reset", rd_data, 0);
    chk(cnt_trig == 0, "R1", "cnt_trig after reset", cnt_trig, 0);
  endtask

  task automatic t_single(input int lane);
    int base, cyc;
    base = pulses[lane];
    bus_write(32'h1 << POS[lane]);
    chk(rd_data == (32'h1 << POS[lane]), "R2", "readback after set",
        rd_data, 32'h1 << POS[lane]);
    chk(pulses[lane] == base, "R5", "no pulse before clear", pulses[lane] - base, 0);
    wait_clear(POS[lane], cyc);
    chk(cyc > 0, "R5", "bit self-clears", cyc, 1);
    chk(pulses[lane] - base == 1, "R5", "pulse issued before clear seen",
        pulses[lane] - base, 1);
    idle(30);
    chk(pulses[lane] - base == 1, "R4", "exactly one pulse", pulses[lane] - base, 1);
  endtask

  task automatic t_zero_unused;
    int base;
    base = pulses[0] + pulses[1] + pulses[2] + pulses[3] + pulses[4];
    bus_write(32'hFFFF_FFC2);
    chk(rd_data == 0, "R3", "unused bits read zero", rd_data, 0);
    idle(40);
    chk(pulses[0] + pulses[1] + pulses[2] + pulses[3] + pulses[4] == base, "R3",
        "unused write fires nothing", pulses[0] + pulses[1] + pulses[2] + pulses[3] + pulses[4] - base, 0);
    base = pulses[3];
    bus_write(32'h10);
    bus_write(32'h0);
    chk(rd_data[4] == 1'b1, "R3", "zero write keeps pending bit", rd_data[4], 1);
    idle(60);
    chk(rd_data == 0 && pulses[3] - base == 1, "R3", "start lane completes once",
        pulses[3] - base, 1);
  endtask

  task automatic t_double;
    int base, cyc;
    base = pulses[2];
    bus_write(32'h8);
    bus_write(32'h8);
    wait_clear(3, cyc);
    idle(40);
    chk(pulses[2] - base == 1, "R6", "repeat write while pending", pulses[2] - base, 1);
  endtask

  task automatic t_multi;
    int base [NT];
    int cyc;
    for (int i = 0; i < NT; i++) base[i] = pulses[i];
    bus_write(32'h3D);
    chk(rd_data == 32'h3D, "R7", "all five pending", rd_data, 32'h3D);
    for (int i = 0; i < NT; i++) wait_clear(POS[i], cyc);
    idle(30);
    for (int i = 0; i < NT; i++)
      chk(pulses[i] - base[i] == 1, "R7", "one pulse per lane", pulses[i] - base[i], 1);
  endtask

  task automatic t_collide;
    int base, zeros, cyc;
    base = pulses[4];
    zeros = 0;
    @(negedge bus_clk);
    wr_en = 1'b1; wr_data = 32'h20;
    for (int c = 0; c < 300; c++) begin
      @(negedge bus_clk);
      if (!rd_data[5]) zeros++;
    end
    wr_en = 1'b0; wr_data = '0;
    chk(zeros == 0, "R10", "set beats clear, never reads 0", zeros, 0);
    wait_clear(5, cyc);
    idle(30);
    chk(pulses[4] - base >= 2, "R10", "further pulses after collisions", pulses[4] - base, 2);
  endtask

  task automatic t_flush;
    int base, cyc;
    base = pulses[1];
    bus_write(32'h4);
    cnt_enable = 1'b0;
    #1;
    chk(rd_data == 0, "R8", "disable clears at once", rd_data, 0);
    bus_write(32'h3D);
    chk(rd_data == 0, "R8", "write while disabled", rd_data, 0);
    idle(40);
    cnt_enable = 1'b1;
    idle(2);
    chk(rd_data == 0, "R8", "nothing pending after re-enable", rd_data, 0);
    chk(pulses[1] - base <= 1, "R9", "flushed request pulses at most once", pulses[1] - base, 1);
    idle(20);
    base = pulses[1];
    bus_write(32'h4);
    wait_clear(2, cyc);
    idle(30);
    chk(cyc > 0 && pulses[1] - base == 1, "R9", "request after re-enable", pulses[1] - base, 1);
  endtask

  initial begin
    #500us;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    idle(4);
    bus_rst_n = 1'b1;
    cnt_rst_n = 1'b1;
    t_reset();
    for (int l = 0; l < NT; l++) t_single(l);
    t_zero_unused();
    t_double();
    t_multi();
    t_collide();
    t_flush();
    // Slow counter clock: completion takes visibly longer
    cnt_half = 13ns;
    idle(20);
    t_single(0);
    t_collide();
    chk(wide_pulses == 0, "R4", "pulses one counter cycle wide", wide_pulses, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule